// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Chain

This block is the digital core of an integer-N synthesizer's dividers. On the feedback side, a prescaler divides the input clock by 10 or by 11. A 9-bit main counter counts the prescaler cycles, and a 4-bit swallow value sets how many of those cycles use the larger modulus. Together they give a total ratio of 10·(M+1)+A. A bypass flag turns this into a plain divide by M+1. In bypass the prescaler and swallow logic sit idle.

On the reference side, a separate 6-bit counter divides its own clock by R+1. Each chain runs on its own clock. Each reports the end of every division period as a one-cycle pulse. The feedback side also exposes the modulus-select line that drives the prescaler.

All divide values come from one 20-bit setting word with a fixed, scrambled bit layout. New values are normally taken up at each chain's terminal count. An immediate-load input makes the chains follow the word at once. Settings that cannot be divided are flagged and repaired.

Top module: `dmd_divider_chain`

## Requirements
- R1: With the bypass bit clear, `fb_pulse` is high for exactly one `fin_clk` cycle, on the last cycle of each period of 10·(M+1)+A cycles; M=511, A=15 gives 5135.
- R2: `mod_sel` is 1 (divide by 11) during the first A prescaler cycles of each feedback period and 0 for the rest, so it is high for 11·A cycles per period. It rises only in the cycle after `fb_pulse`.
- R3: With the bypass bit (word bit 4) set, the feedback period is M+1 `fin_clk` cycles, M=1 giving 2, and `mod_sel` stays 0.
- R4: `ref_pulse` is high for one `ref_clk` cycle at the end of every R+1 reference cycles. With R=0 it is high in every reference cycle.
- R5: The word is decoded as follows. Bit 0 is R5 and bit 1 is R4. Bit 2 is M8 and bit 3 is M7. Bit 4 is bypass. Bits 5 to 11 hold M6 down to M0. Bits 12 to 15 hold R3 down to R0. Bits 16 to 19 hold A3 down to A0.
- R6: With `load_now` low, a word change made during a period leaves that period's length unchanged. The new ratio applies from the next period on, in both chains.
- R7: With `load_now` high, the counters compare against the present word every cycle, so a change made mid-period shortens or lengthens the running period at once.
- R8: The following cases raise `word_bad`. The first is A > M+1 with bypass clear, which is then divided as A = M+1. The second is M=0, which is treated as M=1. A legal word gives `word_bad` = 0.
- R9: During reset `fb_pulse` and `mod_sel` are 0 and `ref_pulse` is 1. After reset the first feedback period uses M=1, A=0 with bypass clear, i.e. 20 cycles. The first reference period uses R=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin_clk | input | 1 | Feedback input clock (divided signal) |
| ref_clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset for both chains |
| freq_word | input | 20 | Packed divide setting (layout in R5) |
| load_now | input | 1 | 1: counters follow the word continuously |
| fb_pulse | output | 1 | One-cycle end-of-period pulse, feedback chain |
| ref_pulse | output | 1 | One-cycle end-of-period pulse, reference chain |
| mod_sel | output | 1 | Prescaler modulus: 1 = divide by 11, 0 = by 10 |
| word_bad | output | 1 | Present word holds an illegal setting |

## Verification
Period lengths and modulus-select counts are measured for several kinds of word. Random legal words separate the A-driven part of the ratio from the M-driven part. The extremes M=1 and M=511 with A=15 expose counter-width and off-by-one faults. A word with A equal to M+1 shows whether `mod_sel` can cover the whole period. Bypass words show whether the swallow logic really goes idle. Mid-period word changes, made with and without `load_now`, separate terminal-count uptake from continuous loading. Illegal words check the flag and the clamped ratio. Because each word is built from its fields by a bench encoder, a scrambled field position shows up as a wrong ratio.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
    localparam int WORD_W  = 20;
    localparam int M_W     = 9;
    localparam int A_W     = 4;
    localparam int R_W     = 6;
    localparam int BYP_BIT = 4;
    localparam int M_MIN   = 1;

    typedef struct packed {
        logic           byp;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
    } fb_cfg_t;

    localparam fb_cfg_t FB_CFG_RST = '{byp: 1'b0, m: M_W'(M_MIN), a: '0};
endpackage

// File: rtl/dmd_word_unpack.sv
module dmd_word_unpack
    import dmd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fb_cfg_t           fb_cfg,
    output logic [R_W-1:0]    r_val,
    output logic              bad
);
    logic [M_W-1:0] raw_m;
    logic [A_W-1:0] raw_a;
    logic [M_W-1:0] m_fix;
    logic [M_W:0]   a_cap;
    logic           a_over;

    // fields are stored most significant bit first in ascending word order
    always_comb begin
        raw_m[M_W-1] = word[2];
        raw_m[M_W-2] = word[3];
        for (int i = 0; i < M_W - 2; i++) raw_m[M_W-3-i] = word[5+i];
        r_val[R_W-1] = word[0];
        r_val[R_W-2] = word[1];
        for (int i = 0; i < R_W - 2; i++) r_val[R_W-3-i] = word[12+i];
        for (int i = 0; i < A_W; i++) raw_a[A_W-1-i] = word[16+i];
    end

    always_comb begin
        m_fix  = (raw_m == '0) ? M_W'(M_MIN) : raw_m;
        a_cap  = {1'b0, m_fix} + (M_W+1)'(1);
        a_over = !word[BYP_BIT] && ({{(M_W+1-A_W){1'b0}}, raw_a} > a_cap);
        fb_cfg.byp = word[BYP_BIT];
        fb_cfg.m   = m_fix;
        fb_cfg.a   = a_over ? a_cap[A_W-1:0] : raw_a;
        bad        = (raw_m == '0) || a_over;
    end
endmodule

// File: rtl/dmd_fb_chain.sv
module dmd_fb_chain
    import dmd_pkg::*;
#(
    parameter int PRE_LO = 10
) (
    input  logic    clk,
    input  logic    rst_n,
    input  fb_cfg_t live_cfg,
    input  logic    load_now,
    output logic    pulse,
    output logic    sel11,
    output logic    act_byp
);
    localparam int PRE_W = $clog2(PRE_LO + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [M_W-1:0]   m_cnt;
        fb_cfg_t          act;
    } fb_state_t;

    fb_state_t        st_d, st_q;
    fb_cfg_t          eff;
    logic [PRE_W-1:0] pre_last;
    logic             pre_end;
    logic             per_end;

    always_comb begin
        eff      = load_now ? live_cfg : st_q.act;
        sel11    = !eff.byp && (st_q.m_cnt < {{(M_W-A_W){1'b0}}, eff.a});
        pre_last = sel11 ? PRE_W'(PRE_LO) : PRE_W'(PRE_LO - 1);
        pre_end  = eff.byp || (st_q.pre >= pre_last);
        per_end  = pre_end && (st_q.m_cnt >= eff.m);

        st_d = st_q;
        if (eff.byp || pre_end) st_d.pre = '0;
        else                    st_d.pre = st_q.pre + PRE_W'(1);
        if (per_end) begin
            st_d.m_cnt = '0;
            st_d.act   = live_cfg;
        end else if (pre_end) begin
            st_d.m_cnt = st_q.m_cnt + M_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pre: '0, m_cnt: '0, act: FB_CFG_RST};
        else        st_q <= st_d;
    end

    assign pulse   = per_end;
    assign act_byp = st_q.act.byp;
endmodule

// File: rtl/dmd_ref_chain.sv
module dmd_ref_chain
    import dmd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] live_r,
    input  logic           load_now,
    output logic           pulse,
    output logic [R_W-1:0] act_r
);
    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic [R_W-1:0] act;
    } ref_state_t;

    ref_state_t     st_d, st_q;
    logic [R_W-1:0] eff_r;
    logic           term;

    always_comb begin
        eff_r = load_now ? live_r : st_q.act;
        term  = st_q.cnt >= eff_r;
        st_d  = st_q;
        if (term) begin
            st_d.cnt = '0;
            st_d.act = live_r;
        end else begin
            st_d.cnt = st_q.cnt + R_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, act: '0};
        else        st_q <= st_d;
    end

    assign pulse = term;
    assign act_r = st_q.act;
endmodule

// File: rtl/dmd_divider_chain.sv
module dmd_divider_chain
    import dmd_pkg::*;
#(
    parameter int PRE_LO = 10
) (
    input  logic              fin_clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] freq_word,
    input  logic              load_now,
    output logic              fb_pulse,
    output logic              ref_pulse,
    output logic              mod_sel,
    output logic              word_bad
);
    fb_cfg_t        live_fb;
    logic [R_W-1:0] live_r;
    logic           act_byp;
    logic [R_W-1:0] act_r;

    dmd_word_unpack u_unpack (
        .word   (freq_word),
        .fb_cfg (live_fb),
        .r_val  (live_r),
        .bad    (word_bad)
    );

    dmd_fb_chain #(.PRE_LO(PRE_LO)) u_fb (
        .clk      (fin_clk),
        .rst_n    (rst_n),
        .live_cfg (live_fb),
        .load_now (load_now),
        .pulse    (fb_pulse),
        .sel11    (mod_sel),
        .act_byp  (act_byp)
    );

    dmd_ref_chain u_ref (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .live_r   (live_r),
        .load_now (load_now),
        .pulse    (ref_pulse),
        .act_r    (act_r)
    );
endmodule

// File: rtl/dmd_divider_chain_chk.sv
module dmd_divider_chain_chk
    import dmd_pkg::*;
(
    input logic           fin_clk,
    input logic           ref_clk,
    input logic           rst_n,
    input logic           load_now,
    input logic           fb_pulse,
    input logic           ref_pulse,
    input logic           mod_sel,
    input logic           act_byp,
    input logic [R_W-1:0] act_r
);
    // feedback period is never shorter than two cycles
    assert_fb_single_R1: assert property (@(posedge fin_clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // the larger modulus only starts a fresh period
    assert_msel_start_R2: assert property (@(posedge fin_clk) disable iff (!rst_n)
        ($rose(mod_sel) && !load_now && !$past(load_now)) |-> $past(fb_pulse));

    // bypassed prescaler never selects divide by 11
    assert_byp_idle_R3: assert property (@(posedge fin_clk) disable iff (!rst_n)
        (act_byp && !load_now) |-> !mod_sel);

    // reference pulse stays one cycle wide unless the new ratio is 1
    assert_ref_single_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ref_pulse && !load_now) |=> (!ref_pulse || act_r == '0 || load_now));
endmodule

bind dmd_divider_chain dmd_divider_chain_chk chk_i (
    .fin_clk   (fin_clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .load_now  (load_now),
    .fb_pulse  (fb_pulse),
    .ref_pulse (ref_pulse),
    .mod_sel   (mod_sel),
    .act_byp   (act_byp),
    .act_r     (act_r)
);

// File: tb/dmd_divider_chain_tb_top.sv
`timescale 1ns/1ps
module dmd_divider_chain_tb_top;
    logic        fin_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic [19:0] freq_word = '0;
    logic        load_now  = 1'b0;
    logic        fb_pulse, ref_pulse, mod_sel, word_bad;
    int n_chk  = 0;
    int n_fail = 0;

    always #5 fin_clk = ~fin_clk;
    always #7 ref_clk = ~ref_clk;

    dmd_divider_chain dut_i (
        .fin_clk(fin_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .freq_word(freq_word), .load_now(load_now),
        .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
        .mod_sel(mod_sel), .word_bad(word_bad)
    );

    // builds a word from fields using the layout of R5
    function automatic logic [19:0] enc(int m, int a, int r, bit byp);
        logic [19:0] w;
        logic [8:0] mv = 9'(m);
        logic [3:0] av = 4'(a);
        logic [5:0] rv = 6'(r);
        w = '0;
        w[0] = rv[5]; w[1] = rv[4]; w[2] = mv[8]; w[3] = mv[7]; w[4] = byp;
        for (int i = 0; i < 7; i++) w[5+i]  = mv[6-i];
        for (int i = 0; i < 4; i++) w[12+i] = rv[3-i];
        for (int i = 0; i < 4; i++) w[16+i] = av[3-i];
        return w;
    endfunction

    function automatic int fix_m(int m);
        return (m == 0) ? 1 : m;
    endfunction

    function automatic int fix_a(int m, int a);
        return (a > fix_m(m) + 1) ? fix_m(m) + 1 : a;
    endfunction

    function automatic int exp_ratio(int m, int a, bit byp);
        if (byp) return fix_m(m) + 1;
        return 10 * (fix_m(m) + 1) + fix_a(m, a);
    endfunction

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_fp();
        do @(negedge fin_clk); while (!fb_pulse);
    endtask

    // counts one feedback period starting at an fb_pulse cycle
    task automatic measure_fp(output int len, output int msel_n, output int first_fp);
        len = 0; msel_n = 0; first_fp = 0;
        do begin
            @(negedge fin_clk);
            len++;
            if (len == 1) first_fp = fb_pulse;
            if (mod_sel) msel_n++;
        end while (!fb_pulse);
    endtask

    task automatic wait_fc();
        do @(negedge ref_clk); while (!ref_pulse);
    endtask

    task automatic measure_fc(output int len);
        len = 0;
        do begin
            @(negedge ref_clk);
            len++;
        end while (!ref_pulse);
    endtask

    task automatic run_cfg(int m, int a, int r, bit byp, string req);
        int len, mc, ff;
        freq_word = enc(m, a, r, byp);
        wait_fp();
        measure_fp(len, mc, ff);
        chk({req, " period"}, len, exp_ratio(m, a, byp));
        chk({req, " mod_sel count"}, mc, byp ? 0 : 11 * fix_a(m, a));
        if (exp_ratio(m, a, byp) > 1) chk("R1 pulse width", ff, 0);
    endtask

    task automatic run_ref(int r, string req);
        int len;
        wait_fc();
        wait_fc();
        measure_fc(len);
        chk(req, len, r + 1);
    endtask

    initial begin
        repeat (190000) @(posedge fin_clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int len, mc, ff, n;
        void'($urandom(32'd4242));
        freq_word = enc(5, 3, 4, 1'b0);
        repeat (3) @(negedge fin_clk);
        chk("R9 reset fb_pulse", int'(fb_pulse), 0);
        chk("R9 reset mod_sel", int'(mod_sel), 0);
        chk("R9 reset ref_pulse", int'(ref_pulse), 1);
        rst_n = 1'b1;
        // first cycle of the 20-cycle default period is already under way
        n = 0;
        do begin @(negedge fin_clk); n++; end while (!fb_pulse);
        chk("R9 first period", n, 19);
        measure_fp(len, mc, ff);
        chk("R1 M=5 A=3 period", len, 63);
        chk("R2 M=5 A=3 mod_sel count", mc, 33);
        run_ref(4, "R4 R=4");

        run_cfg(511, 15, 63, 1'b0, "R1 max");
        run_ref(63, "R4 R=63");
        run_cfg(1, 0, 0, 1'b0, "R1 min");
        run_cfg(1, 2, 0, 1'b0, "R2 A=M+1");
        run_ref(0, "R4 R=0");
        n = 0;
        for (int i = 0; i < 8; i++) begin @(negedge ref_clk); if (ref_pulse) n++; end
        chk("R4 R=0 every cycle", n, 8);
        run_cfg(7, 5, 1, 1'b1, "R3 bypass M=7");
        run_cfg(1, 9, 1, 1'b1, "R3 bypass M=1");

        // R8 illegal words
        freq_word = enc(3, 9, 2, 1'b0);
        #1 chk("R8 flag A>M+1", int'(word_bad), 1);
        run_cfg(3, 9, 2, 1'b0, "R8 clamp A");
        freq_word = enc(0, 0, 2, 1'b0);
        #1 chk("R8 flag M=0", int'(word_bad), 1);
        run_cfg(0, 0, 2, 1'b0, "R8 M=0");
        freq_word = enc(3, 4, 2, 1'b0);
        #1 chk("R8 legal word", int'(word_bad), 0);

        // R6 terminal-count uptake
        run_cfg(10, 0, 2, 1'b0, "R6 setup");
        n = 0;
        repeat (5) begin @(negedge fin_clk); n++; end
        freq_word = enc(3, 2, 2, 1'b0);
        while (!fb_pulse) begin @(negedge fin_clk); n++; end
        chk("R6 running period kept", n, 110);
        measure_fp(len, mc, ff);
        chk("R6 next period new", len, 42);

        // R7 immediate load
        run_cfg(40, 0, 2, 1'b0, "R7 setup");
        load_now = 1'b1;
        n = 0;
        repeat (5) begin @(negedge fin_clk); n++; end
        freq_word = enc(2, 0, 2, 1'b0);
        while (!fb_pulse) begin @(negedge fin_clk); n++; end
        chk("R7 running period cut", n, 30);
        load_now = 1'b0;

        // R5 random layouts
        for (int k = 0; k < 8; k++) begin
            int m, a, r;
            bit byp;
            m   = $urandom_range(60, 1);
            a   = $urandom_range(15, 0);
            r   = $urandom_range(20, 0);
            byp = ($urandom_range(3, 0) == 0);
            if (a > m + 1) a = m + 1;
            run_cfg(m, a, r, byp, "R5 random");
            run_ref(r, "R5 random ref");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule